// File: doc/BRIEF.md
# Flag Offset Loader for a Dual FIFO

This block holds the four threshold offsets that a pair of FIFOs use for their near-empty and near-full flags: one near-empty offset and one near-full offset per FIFO. The flag comparators read the offsets from it continuously. The FIFO storage and the comparators themselves sit outside the block.

At master reset the block samples two pick inputs and a mode input. Three of the pick codes load a fixed preset into all four offsets, and the block reports itself ready at once. The fourth code clears the offsets and waits for a programmed load. That load runs in one of two ways. In serial mode the two pick inputs become a data bit and a shift enable. In parallel mode a write strobe and a data bus deliver one whole offset per write. A ready output rises when the last offset has arrived. Until it rises, the surrounding logic keeps its FIFO flags inactive. A partial reset leaves everything in the block as it is.

Top module: `fol_offset_loader`

## Requirements
- R1: A clock edge with `mrst_n` low and pick code `{pick_hi,pick_lo}` of 0, 1 or 2 loads 8, 16 or 64 respectively into all four offsets and sets `done` to 1.
- R2: A clock edge with `mrst_n` low and pick code 3 sets all four offsets to 0 and `done` to 0.
- R3: `par_mode` is sampled at master reset. A value of 0 selects serial loading and a value of 1 selects parallel loading. The input has no effect at any other time.
- R4: In serial mode with `done` low, each clock with `pick_hi` high shifts `pick_lo` in. The bits go in most significant bit first, filling the offsets in the order `ae_off_a`, `af_off_a`, `ae_off_b`, `af_off_b`. Clocks with `pick_hi` low change nothing.
- R5: In serial mode, `done` rises on the edge that takes in the 4×OFF_W-th enabled bit (40 with defaults). On that same edge all four offsets take their final values. Before that bit, `done` stays 0.
- R6: In parallel mode with `done` low, each clock with `wr_en` high stores `wr_data` into the next offset, in the order `ae_off_a`, `af_off_a`, `ae_off_b`, `af_off_b`. Clocks without `wr_en` change nothing, and offsets not yet written stay 0.
- R7: In parallel mode, `done` rises on the edge of the fourth write.
- R8: Once `done` is 1, serial enables and parallel writes are ignored, and the offsets and `done` hold until the next master reset.
- R9: While `prst_n` is low, the offsets, `done` and the load progress are unchanged, and load inputs are ignored. A load that was interrupted this way resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low; samples pick code and mode |
| prst_n | input | 1 | Partial reset, active low; freezes the block |
| par_mode | input | 1 | Load mode sampled at master reset: 1 parallel, 0 serial |
| pick_lo | input | 1 | Pick code bit 0; serial data bit after reset |
| pick_hi | input | 1 | Pick code bit 1; serial shift enable after reset |
| wr_en | input | 1 | Parallel write strobe |
| wr_data | input | OFF_W | Parallel write data |
| ae_off_a | output | OFF_W | Near-empty offset, FIFO A |
| af_off_a | output | OFF_W | Near-full offset, FIFO A |
| ae_off_b | output | OFF_W | Near-empty offset, FIFO B |
| af_off_b | output | OFF_W | Near-full offset, FIFO B |
| done | output | 1 | All four offsets are valid |

## Verification
All three preset codes are applied under both mode settings. The offsets must come out the same whatever the mode, which separates the preset path from the mode latch. Serial loads use several arithmetic value sets, including all-zero and all-one sets, with idle gaps that toggle the data pin. A misplaced or skipped shift then shows up as a wrong bit in a particular offset, and `done` is checked one bit before the end. Parallel loads are checked after the second write and again after the fourth, which exposes errors in the write order or the counter. They are also interrupted by a partial reset while stray writes are applied, to show that progress is both frozen and kept. After completion, and in preset mode, extra enables and writes are driven to confirm they are ignored.

// File: rtl/fol_pkg.sv
package fol_pkg;

  localparam int unsigned NUM_OFFSETS = 4;

  typedef enum logic [1:0] {
    PICK_D8   = 2'd0,
    PICK_D16  = 2'd1,
    PICK_D64  = 2'd2,
    PICK_PROG = 2'd3
  } pick_code_e;

  // Preset value for a pick code; the programmed code starts from zero.
  function automatic int unsigned preset_value(pick_code_e c);
    case (c)
      PICK_D8:  return 8;
      PICK_D16: return 16;
      PICK_D64: return 64;
      default:  return 0;
    endcase
  endfunction

  function automatic bit loads_preset(pick_code_e c);
    return c != PICK_PROG;
  endfunction

  // Number of serial bits needed to fill every offset.
  function automatic int unsigned serial_total(int unsigned w);
    return NUM_OFFSETS * w;
  endfunction

endpackage

// File: rtl/fol_serial_ctrl.sv
module fol_serial_ctrl #(
  parameter int unsigned TOTAL = 40
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic arm,
  input  logic sen,
  output logic shift_fire,
  output logic last_fire
);
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] bit_cnt_q;

  assign shift_fire = arm && sen;
  assign last_fire  = shift_fire && (bit_cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!mrst_n)         bit_cnt_q <= '0;
    else if (shift_fire) bit_cnt_q <= bit_cnt_q + CNT_W'(1);
  end

  AST_SER_CNT_RANGE: assert property (@(posedge clk) disable iff (!mrst_n)
    bit_cnt_q <= CNT_W'(TOTAL)); // R5
  AST_SER_STEP: assert property (@(posedge clk) disable iff (!mrst_n)
    shift_fire |=> bit_cnt_q == $past(bit_cnt_q) + CNT_W'(1)); // R4
  AST_SER_IDLE: assert property (@(posedge clk) disable iff (!mrst_n)
    !shift_fire |=> $stable(bit_cnt_q)); // R4

endmodule

// File: rtl/fol_par_ctrl.sv
module fol_par_ctrl #(
  parameter int unsigned NOFF = 4,
  localparam int unsigned SLOT_W = (NOFF > 1) ? $clog2(NOFF) : 1
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              arm,
  input  logic              wr_en,
  output logic              wr_fire,
  output logic              last_fire,
  output logic [SLOT_W-1:0] slot
);
  localparam int unsigned IDX_W = $clog2(NOFF + 1);

  logic [IDX_W-1:0] idx_q;

  assign wr_fire   = arm && wr_en;
  assign last_fire = wr_fire && (idx_q == IDX_W'(NOFF - 1));
  assign slot      = idx_q[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!mrst_n)      idx_q <= '0;
    else if (wr_fire) idx_q <= idx_q + IDX_W'(1);
  end

  AST_PAR_IDX_RANGE: assert property (@(posedge clk) disable iff (!mrst_n)
    idx_q <= IDX_W'(NOFF)); // R7
  AST_PAR_STEP: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_fire |=> idx_q == $past(idx_q) + IDX_W'(1)); // R6

endmodule

// File: rtl/fol_offset_store.sv
module fol_offset_store #(
  parameter int unsigned OFF_W = 10,
  parameter int unsigned NOFF  = 4,
  localparam int unsigned SLOT_W = (NOFF > 1) ? $clog2(NOFF) : 1
) (
  input  logic                    clk,
  input  logic                    mrst_n,
  input  logic [OFF_W-1:0]        init_val,
  input  logic                    shift_fire,
  input  logic                    sdin,
  input  logic                    wr_fire,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [OFF_W-1:0]        wr_data,
  output logic [NOFF*OFF_W-1:0]   offs_flat
);
  logic [NOFF-1:0][OFF_W-1:0] slot_q;
  logic [NOFF-1:0]            feed;

  // Serial chain: each slot takes the top bit of the next; the last takes the pin.
  for (genvar i = 0; i < NOFF; i++) begin : g_feed
    if (i == NOFF - 1) begin : g_tail
      assign feed[i] = sdin;
    end else begin : g_link
      assign feed[i] = slot_q[i+1][OFF_W-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NOFF; i++) begin
      if (!mrst_n)
        slot_q[i] <= init_val;
      else if (shift_fire)
        slot_q[i] <= {slot_q[i][OFF_W-2:0], feed[i]};
      else if (wr_fire && (wr_slot == SLOT_W'(i)))
        slot_q[i] <= wr_data;
    end
  end

  assign offs_flat = slot_q;

  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!mrst_n)
    (!shift_fire && !wr_fire) |=> $stable(slot_q)); // R8
  AST_STORE_ONE_PATH: assert property (@(posedge clk) disable iff (!mrst_n)
    !(shift_fire && wr_fire)); // R3

endmodule

// File: rtl/fol_offset_loader.sv
module fol_offset_loader
  import fol_pkg::*;
#(
  parameter int unsigned OFF_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             par_mode,
  input  logic             pick_lo,
  input  logic             pick_hi,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_data,
  output logic [OFF_W-1:0] ae_off_a,
  output logic [OFF_W-1:0] af_off_a,
  output logic [OFF_W-1:0] ae_off_b,
  output logic [OFF_W-1:0] af_off_b,
  output logic             done
);
  localparam int unsigned NOFF   = NUM_OFFSETS;
  localparam int unsigned TOTAL  = serial_total(OFF_W);
  localparam int unsigned SLOT_W = $clog2(NOFF);

  pick_code_e             pick_code;
  logic [OFF_W-1:0]       init_val;
  logic                   mode_par_q;
  logic                   done_q;
  logic                   load_arm;
  logic                   ser_arm, par_arm;
  logic                   ser_fire, ser_last;
  logic                   par_fire, par_last;
  logic [SLOT_W-1:0]      par_slot;
  logic [NOFF*OFF_W-1:0]  offs_flat;

  assign pick_code = pick_code_e'({pick_hi, pick_lo});
  assign init_val  = OFF_W'(preset_value(pick_code));

  // Loading runs only while incomplete and not held by partial reset.
  assign load_arm = !done_q && prst_n;
  assign ser_arm  = load_arm && !mode_par_q;
  assign par_arm  = load_arm &&  mode_par_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_par_q <= par_mode;
      done_q     <= loads_preset(pick_code);
    end else if (ser_last || par_last) begin
      done_q     <= 1'b1;
    end
  end

  fol_serial_ctrl #(.TOTAL(TOTAL)) u_ser (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .arm        (ser_arm),
    .sen        (pick_hi),
    .shift_fire (ser_fire),
    .last_fire  (ser_last)
  );

  fol_par_ctrl #(.NOFF(NOFF)) u_par (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .arm       (par_arm),
    .wr_en     (wr_en),
    .wr_fire   (par_fire),
    .last_fire (par_last),
    .slot      (par_slot)
  );

  fol_offset_store #(.OFF_W(OFF_W), .NOFF(NOFF)) u_store (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .init_val   (init_val),
    .shift_fire (ser_fire),
    .sdin       (pick_lo),
    .wr_fire    (par_fire),
    .wr_slot    (par_slot),
    .wr_data    (wr_data),
    .offs_flat  (offs_flat)
  );

  assign ae_off_a = offs_flat[0*OFF_W +: OFF_W];
  assign af_off_a = offs_flat[1*OFF_W +: OFF_W];
  assign ae_off_b = offs_flat[2*OFF_W +: OFF_W];
  assign af_off_b = offs_flat[3*OFF_W +: OFF_W];
  assign done     = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> done); // R8
  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> $stable(offs_flat)); // R8
  AST_PRST_FREEZE: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(offs_flat) && $stable(done))); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(mode_par_q)); // R3
  AST_SINGLE_PATH: assert property (@(posedge clk) disable iff (!mrst_n)
    !(ser_fire && par_fire)); // R3

endmodule

// File: tb/tb_fol_offset_loader.sv
module tb_fol_offset_loader;
  localparam int W = 10;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, par_mode = 1'b0;
  logic pick_lo = 1'b0, pick_hi = 1'b0, wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] ae_off_a, af_off_a, ae_off_b, af_off_b;
  logic done;

  int n_tests = 0, n_fail = 0;
  int exp_v [4];

  always #10 clk = ~clk;

  fol_offset_loader #(.OFF_W(W)) dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .par_mode(par_mode),
    .pick_lo(pick_lo), .pick_hi(pick_hi), .wr_en(wr_en), .wr_data(wr_data),
    .ae_off_a(ae_off_a), .af_off_a(af_off_a), .ae_off_b(ae_off_b),
    .af_off_b(af_off_b), .done(done)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic chk_all(string req, int edone);
    chk(req, "ae_off_a", int'(ae_off_a), exp_v[0]);
    chk(req, "af_off_a", int'(af_off_a), exp_v[1]);
    chk(req, "ae_off_b", int'(ae_off_b), exp_v[2]);
    chk(req, "af_off_b", int'(af_off_b), exp_v[3]);
    chk(req, "done", int'(done), edone);
  endtask

  task automatic do_mrst(int code, bit pm);
    mrst_n = 1'b0; pick_lo = code[0]; pick_hi = code[1]; par_mode = pm;
    wr_en = 1'b0; prst_n = 1'b1;
    tick(); tick();
    mrst_n = 1'b1; pick_lo = 1'b0; pick_hi = 1'b0; par_mode = ~pm;
  endtask

  function automatic int pat_val(int p, int i);
    if (p == 0) return 0;
    if (p == 1) return 1023;
    return (p * 173 + i * 389 + 5) % 1024;
  endfunction

  task automatic serial_load(int p);
    for (int s = 0; s < 4; s++) begin
      for (int b = W - 1; b >= 0; b--) begin
        if ((s * W + b + p) % 7 == 0) begin
          pick_hi = 1'b0; pick_lo = ~pick_lo; tick();   // idle gap, R4
        end
        pick_lo = exp_v[s][b]; pick_hi = 1'b1;
        if (s == 3 && b == 0)
          chk("R5", "done before last bit", int'(done), 0);
        tick();
      end
    end
    pick_hi = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 / R3: presets under both mode settings
    for (int pm = 0; pm < 2; pm++) begin
      for (int c = 0; c < 3; c++) begin
        do_mrst(c, pm[0]);
        for (int i = 0; i < 4; i++) exp_v[i] = 8 << (c == 0 ? 0 : (c == 1 ? 1 : 3));
        chk_all("R1", 1);
        // R8: load attempts in preset mode ignored
        wr_en = 1'b1; wr_data = 10'd777; pick_hi = 1'b1; pick_lo = 1'b1;
        tick(); tick();
        wr_en = 1'b0; pick_hi = 1'b0;
        chk_all("R8", 1);
      end
    end

    // R2: programmed code clears
    do_mrst(3, 1'b0);
    for (int i = 0; i < 4; i++) exp_v[i] = 0;
    chk_all("R2", 0);

    // R4 / R5: serial loads, several patterns
    for (int p = 0; p < 5; p++) begin
      do_mrst(3, 1'b0);
      for (int i = 0; i < 4; i++) exp_v[i] = pat_val(p, i);
      serial_load(p);
      chk_all("R5", 1);
      // R8: more serial bits after done ignored
      pick_hi = 1'b1;
      for (int k = 0; k < 6; k++) begin pick_lo = k[0]; tick(); end
      pick_hi = 1'b0; wr_en = 1'b1; wr_data = 10'd5; tick(); wr_en = 1'b0;
      chk_all("R8", 1);
    end

    // R3: parallel mode ignores serial enables
    do_mrst(3, 1'b1);
    pick_hi = 1'b1; pick_lo = 1'b1;
    for (int k = 0; k < 12; k++) tick();
    pick_hi = 1'b0;
    for (int i = 0; i < 4; i++) exp_v[i] = 0;
    chk_all("R3", 0);

    // R6 / R7: parallel loads with gaps
    for (int p = 2; p < 5; p++) begin
      do_mrst(3, 1'b1);
      for (int i = 0; i < 4; i++) begin
        wr_data = W'(pat_val(p, i)); wr_en = 1'b1; tick();
        wr_en = 1'b0; wr_data = 10'h3FF;
        if ((i + p) % 2 == 0) tick();
        if (i == 1) begin
          chk("R6", "ae_off_a mid", int'(ae_off_a), pat_val(p, 0));
          chk("R6", "af_off_a mid", int'(af_off_a), pat_val(p, 1));
          chk("R6", "ae_off_b mid", int'(ae_off_b), 0);
          chk("R6", "af_off_b mid", int'(af_off_b), 0);
          chk("R7", "done mid", int'(done), 0);
        end
      end
      for (int i = 0; i < 4; i++) exp_v[i] = pat_val(p, i);
      chk_all("R7", 1);
      wr_en = 1'b1; wr_data = 10'd9; tick(); tick(); wr_en = 1'b0;
      chk_all("R8", 1);
    end

    // R9: partial reset during parallel load, then resume
    do_mrst(3, 1'b1);
    for (int i = 0; i < 4; i++) exp_v[i] = 100 + 200 * i;
    for (int i = 0; i < 2; i++) begin
      wr_data = W'(exp_v[i]); wr_en = 1'b1; tick();
    end
    wr_en = 1'b0;
    prst_n = 1'b0;
    wr_en = 1'b1; wr_data = 10'd1;
    for (int k = 0; k < 3; k++) tick();
    wr_en = 1'b0;
    chk("R9", "ae_off_b frozen", int'(ae_off_b), 0);
    chk("R9", "af_off_a kept", int'(af_off_a), exp_v[1]);
    chk("R9", "done frozen", int'(done), 0);
    prst_n = 1'b1;
    for (int i = 2; i < 4; i++) begin
      wr_data = W'(exp_v[i]); wr_en = 1'b1; tick();
    end
    wr_en = 1'b0;
    chk_all("R9", 1);
    prst_n = 1'b0; tick(); tick(); prst_n = 1'b1;
    chk_all("R9", 1);

    // R9: partial reset during serial load
    do_mrst(3, 1'b0);
    for (int i = 0; i < 4; i++) exp_v[i] = pat_val(7, i);
    prst_n = 1'b0; pick_hi = 1'b1; pick_lo = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    pick_hi = 1'b0; prst_n = 1'b1;
    chk("R9", "serial frozen af_off_b", int'(af_off_b), 0);
    serial_load(3);
    chk_all("R9", 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule